// File: doc/BRIEF.md
# Pipelined Double-Data-Rate Pin Serializer with Matched Enable

This block drives one output pin at twice the clock rate. On every rising clock edge it takes in two bits together: an early bit for the high half of a cycle and a late bit for the low half. The pair moves through a fixed register pipeline before it reaches the output stage. That stage presents the early bit while the clock is high and the late bit while the clock is low.

A single-rate output-enable travels beside the data through a delay line of the same depth. It therefore turns the pad driver on and off in step with the data that leaves the pin. When the delayed enable is low, the pad is meant to be high-impedance.

The pipeline depth is a parameter, with a default of two register stages ahead of the output stage. At the default depth the early bit appears three cycles after capture and the late bit three and a half cycles after capture.

Top module: `ddr_oser_out`

## Requirements
- R1: `d_first`, `d_second` and `oe_in` are all sampled on the same rising edge, and they travel together as one slot.
- R2: A pair captured at rising edge n (edge n counted as edge 1) puts its `d_first` on `q` while `clk` is high after rising edge n+2. With the default depth of 2 this is three cycles of latency.
- R3: The `d_second` of that pair appears on `q` while `clk` is low, in the half cycle right after its `d_first` (3.5 cycles of latency). Within a cycle the late bit always follows the early bit.
- R4: Pairs given on consecutive rising edges come out on `q` as an unbroken stream of alternating early and late bits, with no idle half cycles between them.
- R5: `oe_out` equals the `oe_in` sampled at rising edge n, from rising edge n+2 until the next rising edge. It changes only on rising edges, so it stays constant through the low half of the cycle.
- R6: While `rst` is high at a rising edge (synchronous, active high), every pipeline slot is cleared. `q` and `oe_out` then read 0 until pairs captured after reset reach the pin. A pair sampled while `rst` is high is discarded.
- R7: `oe_out` low means the pad is to be high-impedance. `oe_out` is a registered signal at the rate of the clock, not of the data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data leaves on both of its edges |
| rst | input | 1 | Synchronous active-high reset |
| d_first | input | 1 | Bit driven during the high half of the output cycle |
| d_second | input | 1 | Bit driven during the low half of the output cycle |
| oe_in | input | 1 | Output enable, single rate |
| q | output | 1 | Double-rate data toward the pad |
| oe_out | output | 1 | Delayed pad enable, high = drive, low = high-impedance |

## Verification
A slot that is dropped, repeated or moved to another stage shows up on `q` as a shift of whole cycles. That shift is visible from the third rising edge after the affected capture. A swap of the two bits, or a late bit taken from the wrong cycle, corrupts the very next low half cycle. A data pipeline and an enable line of different lengths make `oe_out` disagree with the expected enable on the first transition of `oe_in`. The bench checks `q` and `oe_out` in both halves of every cycle against a history of applied inputs. It does so across exhaustive sweeps of bit patterns, every ordered pair of consecutive slots, a reset in the middle of a stream, and a pseudo-random stream.

// File: rtl/ddr_oser_pkg.sv
package ddr_oser_pkg;

    // Two bits destined for one output cycle: high half first, low half second.
    typedef struct packed {
        logic early;
        logic late;
    } ddr_pair_t;

    // One pipeline slot: the data pair plus its single-rate enable.
    typedef struct packed {
        ddr_pair_t data;
        logic      drive;
    } ddr_slot_t;

    localparam ddr_slot_t SLOT_IDLE = '{data: '{early: 1'b0, late: 1'b0}, drive: 1'b0};

    function automatic ddr_slot_t pack_slot(input logic a, input logic b, input logic en);
        ddr_slot_t s;
        s.data.early = a;
        s.data.late  = b;
        s.drive      = en;
        return s;
    endfunction

    // Rising edges from capture until the early bit is on the pin.
    function automatic int unsigned pin_latency(input int unsigned depth);
        return depth + 1;
    endfunction

endpackage

// File: rtl/ddr_slot_pipe.sv
module ddr_slot_pipe
    import ddr_oser_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  ddr_slot_t slot_in,
    output ddr_slot_t slot_out
);

    // Register 0 is the capture stage; data and enable share every stage.
    ddr_slot_t stage_q [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage_q[k] <= SLOT_IDLE;
                else     stage_q[k] <= slot_in;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage_q[k] <= SLOT_IDLE;
                else     stage_q[k] <= stage_q[k-1];
            end
        end
    end

    assign slot_out = stage_q[DEPTH-1];

endmodule

// File: rtl/ddr_phase_out.sv
module ddr_phase_out
    import ddr_oser_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  ddr_slot_t slot_in,
    output logic      q,
    output logic      oe_out,
    output logic      hi_bit,
    output logic      lo_bit
);

    ddr_slot_t launch_q;
    logic      late_q;

    // Rising edge: load the whole slot; early bit is on the pin at once.
    always_ff @(posedge clk) begin
        if (rst) launch_q <= SLOT_IDLE;
        else     launch_q <= slot_in;
    end

    // Falling edge: retime the late bit so it owns the low half cycle.
    always_ff @(negedge clk) begin
        late_q <= launch_q.data.late;
    end

    assign hi_bit = launch_q.data.early;
    assign lo_bit = late_q;
    assign q      = clk ? hi_bit : lo_bit;
    assign oe_out = launch_q.drive;

endmodule

// File: rtl/ddr_oser_out.sv
module ddr_oser_out
    import ddr_oser_pkg::*;
#(
    parameter int unsigned PIPE_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_first,
    input  logic d_second,
    input  logic oe_in,
    output logic q,
    output logic oe_out
);

    localparam int unsigned LAT   = pin_latency(PIPE_DEPTH);
    localparam int unsigned AGE_W = $clog2(LAT + 1);

    ddr_slot_t slot_cap;
    ddr_slot_t slot_tail;
    logic      hi_bit;
    logic      lo_bit;

    // R1: all three inputs form one slot sampled on the same edge.
    assign slot_cap = pack_slot(d_first, d_second, oe_in);

    ddr_slot_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .slot_in  (slot_cap),
        .slot_out (slot_tail)
    );

    ddr_phase_out u_phase (
        .clk     (clk),
        .rst     (rst),
        .slot_in (slot_tail),
        .q       (q),
        .oe_out  (oe_out),
        .hi_bit  (hi_bit),
        .lo_bit  (lo_bit)
    );

    // Rising edges since reset, saturating at the pin latency; used by checks.
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)                          age_q <= '0;
        else if (age_q != AGE_W'(LAT))    age_q <= age_q + 1'b1;
    end

    p_reset_clears_r6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!oe_out && !hi_bit))
        else $error("reset did not clear output stage");

    p_early_latency_r2: assert property (@(posedge clk) disable iff (rst)
        (age_q == AGE_W'(LAT)) |-> (hi_bit == $past(d_first, LAT)))
        else $error("early bit latency wrong");

    p_late_latency_r3: assert property (@(posedge clk) disable iff (rst)
        (age_q == AGE_W'(LAT)) |-> (lo_bit == $past(d_second, LAT)))
        else $error("late bit latency wrong");

    p_enable_matched_r5: assert property (@(posedge clk) disable iff (rst)
        (age_q == AGE_W'(LAT)) |-> (oe_out == $past(oe_in, LAT)))
        else $error("enable not aligned with data");

endmodule

// File: tb/ddr_oser_out_tb.sv
`timescale 1ns/1ps
module ddr_oser_out_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic d_first = 1'b0;
    logic d_second = 1'b0;
    logic oe_in = 1'b0;
    logic q;
    logic oe_out;

    ddr_oser_out u_dut (
        .clk      (clk),
        .rst      (rst),
        .d_first  (d_first),
        .d_second (d_second),
        .oe_in    (oe_in),
        .q        (q),
        .oe_out   (oe_out)
    );

    localparam int HIST = 1024;
    localparam int LAG  = 2; // edges between capture edge and launch edge

    int checks = 0;
    int errors = 0;
    int idx    = 0;
    bit finished = 0;
    bit h_r [HIST];
    bit h_a [HIST];
    bit h_b [HIST];
    bit h_e [HIST];

    task automatic check(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (step %0d)", what, act, exp, idx);
        end
    endtask

    // Expected value on the pin after rising edge j; which: 0 early, 1 late, 2 enable.
    function automatic bit expect_at(input int j, input int which);
        if (j < LAG) return 1'b0;
        for (int k = j - LAG; k <= j; k++) if (h_r[k]) return 1'b0;
        case (which)
            0:       return h_a[j-LAG];
            1:       return h_b[j-LAG];
            default: return h_e[j-LAG];
        endcase
    endfunction

    task automatic step(input logic a, input logic b, input logic en, input logic r,
                        input string tag);
        rst = r; d_first = a; d_second = b; oe_in = en;
        h_r[idx] = r; h_a[idx] = a; h_b[idx] = b; h_e[idx] = en;
        @(posedge clk); #3;
        check(q, expect_at(idx, 0), {tag, " R1 R2 early bit in high half"});
        check(oe_out, expect_at(idx, 2), {tag, " R5 R7 enable after rise"});
        @(negedge clk); #3;
        check(q, expect_at(idx, 1), {tag, " R3 late bit in low half"});
        check(oe_out, expect_at(idx, 2), {tag, " R5 enable held over fall"});
        idx++;
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        // R6: reset state and flushing
        for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b1, 1'b1, "R6 reset");
        // R2 R3: each of the 8 patterns held for several cycles
        for (int p = 0; p < 8; p++)
            for (int i = 0; i < 4; i++) step(p[2], p[1], p[0], 1'b0, "sweep");
        // R4: every ordered pair of patterns back to back
        for (int p = 0; p < 8; p++)
            for (int s = 0; s < 8; s++) begin
                step(p[2], p[1], p[0], 1'b0, "R4 pair");
                step(s[2], s[1], s[0], 1'b0, "R4 pair");
            end
        // R6: reset in the middle of a live stream
        step(1'b1, 1'b0, 1'b1, 1'b0, "R6 pre");
        step(1'b0, 1'b1, 1'b1, 1'b0, "R6 pre");
        step(1'b1, 1'b1, 1'b1, 1'b1, "R6 mid reset");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R6 after");
        // R4: pseudo-random continuous stream
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0], lfsr[3], lfsr[6], 1'b0, "R4 stream");
        end
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule